// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital side of a successive-approximation analog-to-digital converter. It holds a trial register whose contents drive an external DAC. One step at a time, it reads back a single comparator bit that says whether the analog input is at or above the DAC output. A pulse on `start` clears the register and begins a conversion. The controller then sets a trial bit, starting at the most significant position and moving down one position per step. It waits for the analog path to settle, and then keeps or drops that bit according to the comparator.

Every conversion takes the same number of clocks, whatever the input level is. That number is `WIDTH * (SETTLE_CYCLES + 1)`. When the last bit has been decided, the final code is written into a result register and `done` pulses high for one clock. The final code remains on both `dac_code` and `result` until the next conversion is accepted. A new `start` may be given in the same cycle that `done` is high, so conversions can run back to back without a gap. A one-hot pointer register tracks which bit is under trial.

Top module: `sar_conv_ctrl`

## Requirements
- R1: Trial bits are applied one at a time, from bit WIDTH-1 down to bit 0. While bit b is under trial, every bit below b on `dac_code` is 0 and bit b is 1.
- R2: A `start` accepted while idle clears the register. On the clock after acceptance, `dac_code` equals only the top bit set (1000 for WIDTH=4), whatever code was held before.
- R3: `cmp_in` = 1 means the analog input is at or above the DAC output, and the trial bit is kept. `cmp_in` = 0 clears the trial bit.
- R4: Each trial code stays on `dac_code` for SETTLE_CYCLES+1 clocks. `cmp_in` is sampled only on the last of those clock edges.
- R5: `done` rises exactly WIDTH*(SETTLE_CYCLES+1) clocks after the edge that accepted `start`. This count does not depend on the comparator values.
- R6: `done` is high for exactly one clock per conversion.
- R7: `result` changes only on the clock where `done` rises, and `result` equals `dac_code` in that cycle. After that, `result` and `dac_code` hold their values while idle, even if `cmp_in` changes.
- R8: A `start` seen while a conversion is running is ignored, and the running trial sequence continues unchanged.
- R9: A `start` that is high during the cycle in which `done` is high is accepted, so a new conversion begins with no idle gap.
- R10: While reset is asserted, `dac_code` and `result` are 0 and `done` is 0.
- R11: With an ideal comparator (`cmp_in` = 1 when `dac_code` <= input), the result equals the input for every code from 0 to 2^WIDTH-1. For example, an input of 5.1 on weights 8/4/2/1 gives the trial codes 1000, 0100, 0110, 0101 and the result 0101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request; accepted only while idle |
| cmp_in | input | 1 | Comparator result; 1 = input at or above the DAC output |
| dac_code | output | WIDTH | Registered trial code driving the external DAC |
| result | output | WIDTH | Registered final code of the last conversion |
| done | output | 1 | One-clock pulse when the result is updated |

## Verification
A wrong bit in the trial register or the pointer shows up on `dac_code` within one trial step, as a code that breaks the expected MSB-first pattern. An off-by-one in the settle timer or the step sequencing moves the `done` pulse away from clock WIDTH*(SETTLE_CYCLES+1), and this is visible at the end of the first conversion. A wrong keep or clear decision is seen as a `result` that differs from the swept input value on the same `done` pulse. The bench sweeps every input code back to back and injects `start` requests during conversions, so errors in the idle/busy state appear at once as trial codes that restart.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_TRIAL = 1'b1
  } sar_state_e;
endpackage

// File: rtl/sar_bit_pointer.sv
module sar_bit_pointer #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  output logic [WIDTH-1:0] ptr,
  output logic             at_lsb
);
  localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst)        ptr <= '0;
    else if (load)  ptr <= TOP_ONLY;
    else if (shift) ptr <= ptr >> 1;
  end

  assign at_lsb = ptr[0];

  // R1: at most one bit is ever under trial
  p_onehot_ptr_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ptr));

  // R1: the pointer only ever moves downward by one position
  p_ptr_walk_r1: assert property (@(posedge clk) disable iff (rst)
    (shift && !load) |=> (ptr == ($past(ptr) >> 1)));
endmodule

// File: rtl/sar_settle_timer.sv
module sar_settle_timer #(
  parameter int SETTLE_CYCLES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic expired
);
  localparam int CW = $clog2(SETTLE_CYCLES + 2);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart)  cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIMIT);

  // R4: the settle count never runs past its limit
  p_timer_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             decide,
  input  logic             keep,
  input  logic [WIDTH-1:0] ptr,
  output logic [WIDTH-1:0] code
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic arm;
    if (i == WIDTH - 1) begin : g_top
      assign arm = 1'b0;
    end else begin : g_low
      assign arm = ptr[i+1];
    end

    always_ff @(posedge clk) begin
      if (rst)          code[i] <= 1'b0;
      else if (load)    code[i] <= (i == WIDTH - 1);
      else if (decide) begin
        if (ptr[i])     code[i] <= keep;
        else if (arm)   code[i] <= 1'b1;
      end
    end
  end

  // R1: bits below the one under trial stay zero
  p_low_clear_r1: assert property (@(posedge clk) disable iff (rst)
    (ptr != '0) |-> ((code & (ptr - 1'b1)) == '0));

  // R3: a low comparator drops the tried bit
  p_drop_bit_r3: assert property (@(posedge clk) disable iff (rst)
    (decide && !load && !keep) |=> ((code & $past(ptr)) == '0));

  // R3: a high comparator keeps the tried bit
  p_keep_bit_r3: assert property (@(posedge clk) disable iff (rst)
    (decide && !load && keep) |=> ((code & $past(ptr)) == $past(ptr)));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH         = 4,
  parameter int SETTLE_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp_in,
  output logic [WIDTH-1:0] dac_code,
  output logic [WIDTH-1:0] result,
  output logic             done
);
  localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  sar_state_e       state;
  logic             go;
  logic             decide;
  logic             last;
  logic             expired;
  logic             at_lsb;
  logic [WIDTH-1:0] ptr;
  logic [WIDTH-1:0] code;

  assign go     = (state == ST_IDLE) && start;
  assign decide = (state == ST_TRIAL) && expired;
  assign last   = decide && at_lsb;

  always_ff @(posedge clk) begin
    if (rst)       state <= ST_IDLE;
    else if (go)   state <= ST_TRIAL;
    else if (last) state <= ST_IDLE;
  end

  sar_bit_pointer #(.WIDTH(WIDTH)) ptr_i (
    .clk    (clk),
    .rst    (rst),
    .load   (go),
    .shift  (decide),
    .ptr    (ptr),
    .at_lsb (at_lsb)
  );

  sar_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .restart (go | decide),
    .expired (expired)
  );

  sar_trial_reg #(.WIDTH(WIDTH)) trial_i (
    .clk    (clk),
    .rst    (rst),
    .load   (go),
    .decide (decide),
    .keep   (cmp_in),
    .ptr    (ptr),
    .code   (code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= last;
      if (last) result <= (code & ~ptr) | (cmp_in ? ptr : '0);
    end
  end

  assign dac_code = code;

  // R2: an accepted start presents only the top bit
  p_first_trial_r2: assert property (@(posedge clk) disable iff (rst)
    go |=> (dac_code == TOP_ONLY));

  // R6: done never lasts two clocks
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: result only moves together with done
  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  // R7: published result matches the code left on the DAC
  p_result_match_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (result == dac_code));

  // R8: a start during a settle step does not disturb the trial code
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TRIAL && start && !decide) |=> $stable(dac_code));
endmodule

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb_top;
  localparam int N = 4;
  localparam int S = 1;
  localparam int K = N * (S + 1);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [N-1:0] vin = '0;
  logic         cmp_in;
  logic [N-1:0] dac_code;
  logic [N-1:0] result;
  logic         done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  // ideal comparator: high when the DAC level does not exceed the input
  assign cmp_in = (dac_code <= vin);

  sar_conv_ctrl #(.WIDTH(N), .SETTLE_CYCLES(S)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cmp_in   (cmp_in),
    .dac_code (dac_code),
    .result   (result),
    .done     (done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int v, input int b);
    int pos = N - 1 - b;
    return (v & ~((1 << (pos + 1)) - 1)) | (1 << pos);
  endfunction

  task automatic convert(input int v, input bit noise, input bit chained);
    start = 1'b1;
    vin   = v[N-1:0];
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R2 first trial code", int'(dac_code), exp_code(v, 0));
    if (chained) chk("R6 done dropped / R9 back-to-back start", int'(done), 0);
    for (int k = 1; k < K; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R5 done early", int'(done), 0);
      chk(noise ? "R8 trial code under busy start" : "R1 R4 trial code",
          int'(dac_code), exp_code(v, k / (S + 1)));
      if (noise && k == 2) start = 1'b1;
      if (k == 3) start = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R5 done timing", int'(done), 1);
    chk("R11 R3 result", int'(result), v);
    chk("R7 dac_code matches result", int'(dac_code), v);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R5 watchdog expired actual %0d expected below 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset dac_code", int'(dac_code), 0);
    chk("R10 reset result", int'(result), 0);
    chk("R10 reset done", int'(done), 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);

    for (int v = 0; v < (1 << N); v++) begin
      convert(v, (v % 3) == 1, v > 0);
    end

    start = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R6 single pulse", int'(done), 0);
    for (int i = 0; i < 5; i++) begin
      vin = i[N-1:0];
      @(posedge clk);
      @(negedge clk);
      chk("R7 result held while idle", int'(result), (1 << N) - 1);
      chk("R7 dac_code held while idle", int'(dac_code), (1 << N) - 1);
      chk("R6 no done while idle", int'(done), 0);
    end

    convert(5, 1'b0, 1'b0);
    convert(10, 1'b1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule